// File: doc/BRIEF.md
# Valid-Ready Stream Arbiter

This block merges several valid/ready input streams onto a single output stream. Every input carries a payload of configurable width and a one-bit end-of-burst marker. One input is chosen per cycle, its payload and marker go to the output, and the output ready is sent back to that chosen input only. The output also reports the index of the chosen input.

Two static parameters shape the behaviour. The selection policy can be lowest-index priority, rotating (round-robin) priority, or a strict ordered sequence that starts at input 0. The hold policy controls whether the choice can move while a transfer is pending. It can move freely, it can be held until the presented beat is accepted, or it can be held until the beat that carries the end-of-burst marker is accepted. The output path is combinational from the inputs, with no buffering. Output valid never depends on output ready.

Top module: `strm_arb`

## Requirements
- R1: With lowest-index selection, whenever several inputs are valid, the smallest valid index is chosen and shown on `out_sel`.
- R2: With rotating selection, the search starts at the input one past the last accepted one, wrapping after the top index. The start point is input 0 after reset and moves only when a transfer completes.
- R3: With ordered selection, inputs are served in the order 0, 1, 2, ... with wrap. While the expected input is not valid, `out_valid` stays low even if other inputs are valid.
- R4: With no hold, the choice may change on any cycle, including while the output is stalled, so `out_data` may change before the beat is accepted.
- R5: With per-beat hold, once a beat is presented and stalled, `out_sel` stays the same until a transfer occurs.
- R6: With burst hold, `out_sel` stays on the chosen input across accepted beats until a beat with `in_last` set is accepted on that input.
- R7: A transfer occurs only on a cycle where `out_valid` and `out_ready` are both high. When `out_ready` is low, no `in_ready` bit is high.
- R8: At most one `in_ready` bit is high, and it is the bit for the input shown on `out_sel`.
- R9: `out_valid`, `out_data` and `out_last` come from the chosen input, and `out_valid` does not depend on `out_ready`.
- R10: After the synchronous active-high reset, with no input valid, `out_valid` and all `in_ready` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | Per-input valid |
| in_data | input | N*DATA_W | Input payloads, input i at bits [i*DATA_W +: DATA_W] |
| in_last | input | N | Per-input end-of-burst marker |
| in_ready | output | N | Per-input ready, high only for the chosen input |
| out_valid | output | 1 | Output valid |
| out_ready | input | 1 | Output ready from the consumer |
| out_data | output | DATA_W | Chosen payload |
| out_last | output | 1 | Chosen end-of-burst marker |
| out_sel | output | SEL_W | Index of the chosen input |

## Verification
The bench builds four copies with four inputs and 8-bit payloads. The first uses rotating selection with per-beat hold. The second uses lowest-index selection with no hold. The third uses ordered selection with per-beat hold. The fourth uses lowest-index selection with burst hold. Together they cover the wrap of the rotating pointer, a stall that is held against a higher-priority request, payload changes during a stall, ordered waiting with other inputs valid, and a burst held open against a lower index.

// File: rtl/strm_arb_pkg.sv
package strm_arb_pkg;
  typedef enum logic [1:0] {
    ARB_LOWEST  = 2'd0,
    ARB_ROTATE  = 2'd1,
    ARB_ORDERED = 2'd2
  } arb_policy_e;

  typedef enum logic [1:0] {
    HOLD_NONE  = 2'd0,
    HOLD_BEAT  = 2'd1,
    HOLD_BURST = 2'd2
  } hold_policy_e;
endpackage

// File: rtl/strm_arb_pick.sv
// Candidate selection for the configured policy.
module strm_arb_pick
  import strm_arb_pkg::*;
#(
  parameter int          N      = 4,
  parameter int          SEL_W  = 2,
  parameter arb_policy_e POLICY = ARB_ROTATE
) (
  input  logic [N-1:0]     req,
  input  logic [SEL_W-1:0] ptr,
  output logic             hit,
  output logic [SEL_W-1:0] idx
);
  generate
    if (POLICY == ARB_LOWEST) begin : g_lowest
      always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
          if (req[i]) begin
            hit = 1'b1;
            idx = SEL_W'(i);
          end
        end
      end
    end else if (POLICY == ARB_ROTATE) begin : g_rotate
      always_comb begin
        logic [SEL_W:0] pos;
        hit = 1'b0;
        idx = '0;
        pos = '0;
        for (int k = N - 1; k >= 0; k--) begin
          pos = {1'b0, ptr} + (SEL_W + 1)'(k);
          if (pos >= (SEL_W + 1)'(N)) pos = pos - (SEL_W + 1)'(N);
          if (req[pos[SEL_W-1:0]]) begin
            hit = 1'b1;
            idx = pos[SEL_W-1:0];
          end
        end
      end
    end else begin : g_ordered
      always_comb begin
        hit = req[ptr];
        idx = ptr;
      end
    end
  endgenerate
endmodule

// File: rtl/strm_arb_hold.sv
// Keeps the current choice according to the hold policy.
module strm_arb_hold
  import strm_arb_pkg::*;
#(
  parameter int           N     = 4,
  parameter int           SEL_W = 2,
  parameter hold_policy_e HOLD  = HOLD_BEAT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             stall,
  input  logic             last,
  input  logic [SEL_W-1:0] cur_idx,
  output logic             hold_on,
  output logic [SEL_W-1:0] hold_idx
);
  logic set_c, clr_c;

  always_comb begin
    case (HOLD)
      HOLD_BEAT: begin
        set_c = stall;
        clr_c = fire;
      end
      HOLD_BURST: begin
        set_c = stall || (fire && !last);
        clr_c = fire && last;
      end
      default: begin
        set_c = 1'b0;
        clr_c = fire || last;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_on  <= 1'b0;
      hold_idx <= '0;
    end else if (clr_c) begin
      hold_on <= 1'b0;
    end else if (set_c && !hold_on) begin
      hold_on  <= 1'b1;
      hold_idx <= cur_idx;
    end
  end
endmodule

// File: rtl/strm_arb_ptr.sv
// Start pointer for the rotating and ordered policies.
module strm_arb_ptr
  import strm_arb_pkg::*;
#(
  parameter int           N     = 4,
  parameter int           SEL_W = 2,
  parameter hold_policy_e HOLD  = HOLD_BEAT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             last,
  input  logic [SEL_W-1:0] gnt_idx,
  output logic [SEL_W-1:0] ptr
);
  localparam logic [SEL_W-1:0] TOP = SEL_W'(N - 1);
  logic advance;

  assign advance = fire && ((HOLD != HOLD_BURST) || last);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (advance) begin
      ptr <= (gnt_idx == TOP) ? '0 : gnt_idx + 1'b1;
    end
  end
endmodule

// File: rtl/strm_arb.sv
module strm_arb
  import strm_arb_pkg::*;
#(
  parameter int           N      = 4,
  parameter int           DATA_W = 8,
  parameter arb_policy_e  POLICY = ARB_ROTATE,
  parameter hold_policy_e HOLD   = HOLD_BEAT,
  parameter int           SEL_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        in_valid,
  input  logic [N*DATA_W-1:0] in_data,
  input  logic [N-1:0]        in_last,
  output logic [N-1:0]        in_ready,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_last,
  output logic [SEL_W-1:0]    out_sel
);
  logic [SEL_W-1:0] ptr, pick_idx, hold_idx, gnt;
  logic             pick_hit, hold_on, fire, stall;

  strm_arb_pick #(.N(N), .SEL_W(SEL_W), .POLICY(POLICY)) u_pick (
    .req(in_valid), .ptr(ptr), .hit(pick_hit), .idx(pick_idx)
  );

  assign gnt       = hold_on ? hold_idx : pick_idx;
  assign out_valid = hold_on ? in_valid[hold_idx] : pick_hit;
  assign out_data  = in_data[gnt*DATA_W +: DATA_W];
  assign out_last  = in_last[gnt];
  assign out_sel   = gnt;
  assign fire      = out_valid && out_ready;
  assign stall     = out_valid && !out_ready;

  strm_arb_hold #(.N(N), .SEL_W(SEL_W), .HOLD(HOLD)) u_hold (
    .clk(clk), .rst(rst), .fire(fire), .stall(stall), .last(out_last),
    .cur_idx(gnt), .hold_on(hold_on), .hold_idx(hold_idx)
  );

  strm_arb_ptr #(.N(N), .SEL_W(SEL_W), .HOLD(HOLD)) u_ptr (
    .clk(clk), .rst(rst), .fire(fire), .last(out_last),
    .gnt_idx(gnt), .ptr(ptr)
  );

  generate
    for (genvar i = 0; i < N; i++) begin : g_ready
      assign in_ready[i] = fire && (gnt == SEL_W'(i));
    end
  endgenerate
endmodule

// File: rtl/strm_arb_chk.sv
module strm_arb_chk
  import strm_arb_pkg::*;
#(
  parameter int           N      = 4,
  parameter arb_policy_e  POLICY = ARB_ROTATE,
  parameter hold_policy_e HOLD   = HOLD_BEAT,
  parameter int           SEL_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     in_valid,
  input logic [N-1:0]     in_last,
  input logic [N-1:0]     in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last,
  input logic [SEL_W-1:0] out_sel
);
  localparam logic [SEL_W-1:0] TOP = SEL_W'(N - 1);

  // R8
  ready_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_ready));
  // R8
  ready_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (|in_ready) |-> in_ready[out_sel]);
  // R7
  no_ready_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !out_ready |-> (in_ready == '0));
  // R9
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (in_valid[out_sel] && (out_last == in_last[out_sel])));

  generate
    if (HOLD == HOLD_BEAT) begin : g_beat
      // R5
      beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_sel));
    end
    if (HOLD == HOLD_BURST) begin : g_burst
      // R6
      burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !(out_ready && out_last)) |=> $stable(out_sel));
    end
    if (POLICY == ARB_LOWEST && HOLD == HOLD_NONE) begin : g_low
      // R1
      lowest_win_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid[0] |-> (out_valid && out_sel == '0));
    end
    if (POLICY == ARB_ORDERED) begin : g_ord
      // R3
      order_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && (HOLD != HOLD_BURST || out_last)) |=>
        (out_sel == (($past(out_sel) == TOP) ? '0 : $past(out_sel) + 1'b1)));
    end
  endgenerate
endmodule

bind strm_arb strm_arb_chk #(.N(N), .POLICY(POLICY), .HOLD(HOLD), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/strm_arb_tb.sv
module strm_arb_tb;
  import strm_arb_pkg::*;

  localparam int N = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic [N*DW-1:0] dat;
  logic [N-1:0] v_a, l_a, r_a_o, v_b, l_b, r_b_o, v_c, l_c, r_c_o, v_d, l_d, r_d_o;
  logic rdy_a, rdy_b, rdy_c, rdy_d;
  logic ov_a, ov_b, ov_c, ov_d, ol_a, ol_b, ol_c, ol_d;
  logic [DW-1:0] od_a, od_b, od_c, od_d;
  logic [1:0] os_a, os_b, os_c, os_d;

  strm_arb #(.N(N), .DATA_W(DW), .POLICY(ARB_ROTATE), .HOLD(HOLD_BEAT)) u_dut (
    .clk(clk), .rst(rst), .in_valid(v_a), .in_data(dat), .in_last(l_a), .in_ready(r_a_o),
    .out_valid(ov_a), .out_ready(rdy_a), .out_data(od_a), .out_last(ol_a), .out_sel(os_a));
  strm_arb #(.N(N), .DATA_W(DW), .POLICY(ARB_LOWEST), .HOLD(HOLD_NONE)) u_lo (
    .clk(clk), .rst(rst), .in_valid(v_b), .in_data(dat), .in_last(l_b), .in_ready(r_b_o),
    .out_valid(ov_b), .out_ready(rdy_b), .out_data(od_b), .out_last(ol_b), .out_sel(os_b));
  strm_arb #(.N(N), .DATA_W(DW), .POLICY(ARB_ORDERED), .HOLD(HOLD_BEAT)) u_sq (
    .clk(clk), .rst(rst), .in_valid(v_c), .in_data(dat), .in_last(l_c), .in_ready(r_c_o),
    .out_valid(ov_c), .out_ready(rdy_c), .out_data(od_c), .out_last(ol_c), .out_sel(os_c));
  strm_arb #(.N(N), .DATA_W(DW), .POLICY(ARB_LOWEST), .HOLD(HOLD_BURST)) u_bl (
    .clk(clk), .rst(rst), .in_valid(v_d), .in_data(dat), .in_last(l_d), .in_ready(r_d_o),
    .out_valid(ov_d), .out_ready(rdy_d), .out_data(od_d), .out_last(ol_d), .out_sel(os_d));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // scoreboard for the rotating copy: expected {sel, data} per transfer
  logic [9:0] exp_q[$];
  always @(negedge clk) begin
    if (!rst && ov_a && rdy_a) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected transfer", int'(os_a), -1);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk(os_a == e[9:8], "R2 sel", int'(os_a), int'(e[9:8]));
        chk(od_a == e[7:0], "R9 data", int'(od_a), int'(e[7:0]));
      end
    end
  end

  function automatic logic [9:0] item(input int p);
    return {2'(p), 8'(8'hA0 + p)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < N; p++) dat[p*DW +: DW] = 8'(8'hA0 + p);
    {v_a, v_b, v_c, v_d} = '0;
    {l_a, l_b, l_c, l_d} = '0;
    {rdy_a, rdy_b, rdy_c, rdy_d} = '0;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R10
    chk(!ov_a && !ov_b && !ov_c && !ov_d, "R10 out_valid", int'({ov_a, ov_b, ov_c, ov_d}), 0);
    chk((r_a_o | r_b_o | r_c_o | r_d_o) == '0, "R10 in_ready", int'(r_a_o | r_b_o | r_c_o | r_d_o), 0);

    // R2: rotation from port 0 with all inputs valid
    v_a = 4'b1111; rdy_a = 1'b1;
    for (int k = 0; k < 5; k++) exp_q.push_back(item(k % N));
    repeat (5) @(posedge clk);
    #1;
    // pointer now at 1; R5 stall on port 2
    v_a = 4'b0100; rdy_a = 1'b0;
    #1;
    chk(os_a == 2'd2, "R5 initial sel", int'(os_a), 2);
    chk(r_a_o == '0, "R7 no ready when stalled", int'(r_a_o), 0);
    step();
    v_a = 4'b0110;
    #1;
    chk(os_a == 2'd2, "R5 held over port 1", int'(os_a), 2);
    rdy_a = 1'b1;
    exp_q.push_back(item(2));
    #1;
    chk(r_a_o == 4'b0100, "R8 ready to chosen only", int'(r_a_o), 4);
    step();
    rdy_a = 1'b0;
    #1;
    chk(os_a == 2'd1, "R2 wrap search from 3", int'(os_a), 1);
    chk(exp_q.size() == 0, "R2 all transfers seen", exp_q.size(), 0);
    v_a = '0;

    // R1 and R4 on the lowest-index, no-hold copy
    v_b = 4'b1010;
    #1;
    chk(os_b == 2'd1 && ov_b, "R1 lowest of 1010", int'(os_b), 1);
    step();
    v_b = 4'b1100;
    #1;
    chk(os_b == 2'd2, "R1 lowest of 1100", int'(os_b), 2);
    step();
    v_b = 4'b1000;
    #1;
    chk(os_b == 2'd3, "R4 stalled on 3", int'(os_b), 3);
    step();
    v_b = 4'b1001;
    #1;
    chk(os_b == 2'd0, "R4 moves while stalled", int'(os_b), 0);
    chk(od_b == 8'hA0, "R4 payload changes", int'(od_b), 'hA0);
    // R9: out_valid unaffected by out_ready
    step();
    v_b = 4'b0001;
    #1;
    chk(ov_b, "R9 valid with ready low", int'(ov_b), 1);
    rdy_b = 1'b1;
    #1;
    chk(ov_b, "R9 valid with ready high", int'(ov_b), 1);
    step();
    v_b = '0; rdy_b = 1'b0;

    // R3 ordered copy
    v_c = 4'b1110; rdy_c = 1'b1;
    #1;
    chk(!ov_c && r_c_o == '0, "R3 waits for port 0", int'(ov_c), 0);
    step();
    v_c = 4'b1111;
    #1;
    chk(ov_c && os_c == 2'd0, "R3 first port 0", int'(os_c), 0);
    step();
    chk(ov_c && os_c == 2'd1, "R3 then port 1", int'(os_c), 1);
    step();
    v_c = 4'b1011;
    #1;
    chk(!ov_c && os_c == 2'd2, "R3 waits for port 2", int'(ov_c), 0);
    step();
    v_c = '0; rdy_c = 1'b0;

    // R6 burst copy
    v_d = 4'b1000; l_d = 4'b0000; rdy_d = 1'b1;
    #1;
    chk(os_d == 2'd3, "R6 burst start", int'(os_d), 3);
    step();
    v_d = 4'b1001;
    #1;
    chk(os_d == 2'd3 && od_d == 8'hA3, "R6 held over port 0", int'(os_d), 3);
    l_d = 4'b1000;
    #1;
    chk(ol_d, "R9 last follows chosen", int'(ol_d), 1);
    step();
    l_d = '0;
    #1;
    chk(os_d == 2'd0, "R6 released after last", int'(os_d), 0);
    v_d = '0; rdy_d = 1'b0;
    step();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule